// File: doc/BRIEF.md
# DMA Channel Sequencer

This block runs one DMA channel. It loads a source address, a destination address, a beat width, a block count, a transfer count and a trigger mode. It then moves data one beat at a time. Each beat is a single read request followed by a single write request on a simple request/acknowledge memory port. The word that was read is held in one internal register and written out unchanged. The total number of beats in a job is the block count multiplied by the transfer count.

Jobs start in one of two ways. In the software modes a start pulse begins the job. In the hardware modes the same start pulse only arms the channel, and a peripheral request line then paces the job; the channel answers each served request with a one-cycle acknowledge pulse. Control inputs allow a job to be paused or stopped early. When a job ends, the block holds an outcome code and can pulse an interrupt that is enabled separately for good and bad outcomes. An optional reload makes the next job begin again at the programmed addresses.

Top module: `dma_chan_engine`

## Requirements
- R1: When a beat completes, each address advances by 1, 2 or 4 for width code 0, 1 or 2/3 (byte, half-word, word). An address whose fixed flag is set does not move.
- R2: A job moves (cfg_blocks+1) × (cfg_xfers+1) beats. A job that finishes normally ends with done_code 1 and busy low.
- R3: Every beat reads from the source address and then writes the data read to the destination address. mem_we is 0 for the read and 1 for the write, and mem_size carries the width code.
- R4: Mode codes 0 (software block) and 1 (software burst) start on ctl_start. Codes 2 (hardware demand), 3 (hardware block) and 4 (hardware burst) make no request until per_req is high.
- R5: Software block mode leaves the memory port idle for exactly one cycle between blocks. Software burst mode keeps the port requesting without a gap until the job ends.
- R6: per_ack pulses once per beat in hardware demand mode, once per block in hardware block mode, and once per job in hardware burst mode. It never pulses in software modes.
- R7: If cfg_reload was 0 for the previous job, a new start continues from the addresses where that job left off. If cfg_reload was 1, or after reset, the new start takes cfg_src_addr and cfg_dst_addr.
- R8: While ctl_pause is high, no new memory request starts and no counts or addresses change. Releasing the pause resumes the job.
- R9: A ctl_stop pulse ends the job at the next beat boundary with done_code 3. The last job beat completing takes precedence over the stop.
- R10: A mem_err response ends the job at once with done_code 2. The failing beat is not written.
- R11: irq pulses for one cycle at the end of a job when cfg_ok_irq_en is set and the code is 1, or when cfg_err_irq_en is set and the code is 2 or 3.
- R12: A start with mode code 5, 6 or 7 makes no request and sets done_code 2 on the next cycle.
- R13: Once mem_req is high, it stays high with mem_addr and mem_we unchanged until mem_ack.
- R14: After reset busy, mem_req, per_ack, irq and done_code are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_src_addr | input | AW | Programmed source start address |
| cfg_dst_addr | input | AW | Programmed destination start address |
| cfg_width | input | 2 | Beat width: 0 byte, 1 half-word, 2/3 word |
| cfg_src_fixed | input | 1 | Source address stays fixed |
| cfg_dst_fixed | input | 1 | Destination address stays fixed |
| cfg_blocks | input | BLK_W | Beats per block minus one |
| cfg_xfers | input | XFER_W | Blocks per job minus one |
| cfg_mode | input | 3 | Trigger mode code (see R4) |
| cfg_reload | input | 1 | Restart at programmed addresses after this job |
| cfg_ok_irq_en | input | 1 | Interrupt on normal completion |
| cfg_err_irq_en | input | 1 | Interrupt on error or stop |
| ctl_start | input | 1 | Start/arm pulse, taken while idle |
| ctl_stop | input | 1 | Forced stop pulse |
| ctl_pause | input | 1 | Pause level |
| per_req | input | 1 | Peripheral transfer request |
| per_ack | output | 1 | One-cycle acknowledge of a served request |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Request address |
| mem_size | output | 2 | Beat width code |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with mem_ack |
| mem_ack | input | 1 | Request accepted and finished |
| mem_err | input | 1 | Error response, valid with mem_ack |
| busy | output | 1 | Job running or armed |
| done_code | output | 2 | 0 none, 1 ok, 2 error, 3 stopped |
| irq | output | 1 | Completion interrupt pulse |

## Verification
The hardest cases to reach from the ports involve a control input arriving while a bus request is already outstanding. A pause that lands during a read must let that read and its write finish and then hold. A stop must wait for the beat boundary. The bench raises pause and stop at fixed cycle offsets inside long burst jobs while the memory model adds random wait states. It then checks that writes stop growing during the pause, and that a stopped job wrote fewer beats, every one of them at the correct address. Error responses are injected at a chosen read or write operation, and the number of completed writes is checked exactly.

// File: rtl/dma_chan_pkg.sv
`timescale 1ns/1ps
package dma_chan_pkg;
   typedef enum logic [2:0] {
      MODE_SW_BLOCK  = 3'd0,
      MODE_SW_BURST  = 3'd1,
      MODE_HW_DEMAND = 3'd2,
      MODE_HW_BLOCK  = 3'd3,
      MODE_HW_BURST  = 3'd4
   } mode_e;

   typedef enum logic [1:0] {
      END_NONE = 2'd0,
      END_OK   = 2'd1,
      END_ERR  = 2'd2,
      END_STOP = 2'd3
   } end_e;

   typedef enum logic [2:0] {
      ST_IDLE, ST_WAIT, ST_READ, ST_WRITE, ST_GAP
   } state_e;

   function automatic logic mode_ok(input logic [2:0] m);
      return m <= 3'd4;
   endfunction

   function automatic logic mode_hw(input logic [2:0] m);
      return (m >= 3'd2) && (m <= 3'd4);
   endfunction
endpackage

// File: rtl/dma_chan_addr.sv
`timescale 1ns/1ps
module dma_chan_addr #(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  logic          adv,
   input  logic          fixed,
   input  logic [1:0]    width,
   output logic [AW-1:0] addr
);
   localparam int STEP_W = 3;
   logic [STEP_W-1:0] step;

   always_comb begin
      if (fixed) step = '0;
      else begin
         case (width)
            2'd0:    step = 3'd1;
            2'd1:    step = 3'd2;
            default: step = 3'd4;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    addr <= '0;
      else if (load) addr <= load_val;
      else if (adv)  addr <= addr + AW'(step);
   end

   // R1
   fixed_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && fixed && !load) |=> $stable(addr));
   // R1
   moving_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !fixed && !load) |=> (addr != $past(addr)));
endmodule

// File: rtl/dma_chan_count.sv
`timescale 1ns/1ps
module dma_chan_count #(
   parameter int BLK_W  = 4,
   parameter int XFER_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BLK_W-1:0]  blk_init,
   input  logic [XFER_W-1:0] xfer_init,
   input  logic              adv,
   output logic              blk_last,
   output logic              job_last
);
   logic [BLK_W-1:0]  blk_left, blk_top;
   logic [XFER_W-1:0] xfer_left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blk_left  <= '0;
         blk_top   <= '0;
         xfer_left <= '0;
      end else if (load) begin
         blk_left  <= blk_init;
         blk_top   <= blk_init;
         xfer_left <= xfer_init;
      end else if (adv) begin
         if (blk_left == '0) begin
            blk_left <= blk_top;
            if (xfer_left != '0) xfer_left <= xfer_left - XFER_W'(1);
         end else begin
            blk_left <= blk_left - BLK_W'(1);
         end
      end
   end

   assign blk_last = (blk_left == '0);
   assign job_last = blk_last && (xfer_left == '0);

   // R2
   xfer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !load && blk_last && !job_last) |=> (xfer_left == $past(xfer_left) - XFER_W'(1)));
   // R2
   xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !load && !blk_last) |=> $stable(xfer_left));
endmodule

// File: rtl/dma_chan_engine.sv
`timescale 1ns/1ps
module dma_chan_engine
   import dma_chan_pkg::*;
#(
   parameter int AW     = 32,
   parameter int DW     = 32,
   parameter int BLK_W  = 4,
   parameter int XFER_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW-1:0]     cfg_src_addr,
   input  logic [AW-1:0]     cfg_dst_addr,
   input  logic [1:0]        cfg_width,
   input  logic              cfg_src_fixed,
   input  logic              cfg_dst_fixed,
   input  logic [BLK_W-1:0]  cfg_blocks,
   input  logic [XFER_W-1:0] cfg_xfers,
   input  logic [2:0]        cfg_mode,
   input  logic              cfg_reload,
   input  logic              cfg_ok_irq_en,
   input  logic              cfg_err_irq_en,
   input  logic              ctl_start,
   input  logic              ctl_stop,
   input  logic              ctl_pause,
   input  logic              per_req,
   output logic              per_ack,
   output logic              mem_req,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [1:0]        mem_size,
   output logic [DW-1:0]     mem_wdata,
   input  logic [DW-1:0]     mem_rdata,
   input  logic              mem_ack,
   input  logic              mem_err,
   output logic              busy,
   output logic [1:0]        done_code,
   output logic              irq
);
   localparam int N_PTR = 2;

   if (DW != 32) begin : g_dw_bad
      $error("dma_chan_engine: DW must be 32 for word beats");
   end
   if (AW < 8) begin : g_aw_bad
      $error("dma_chan_engine: AW too small");
   end
   if (BLK_W < 1 || BLK_W > 8 || XFER_W < 1 || XFER_W > 24) begin : g_cnt_bad
      $error("dma_chan_engine: count widths out of range");
   end

   state_e        st;
   end_e          done_q;
   logic [2:0]    mode_q;
   logic [1:0]    width_q;
   logic          sfix_q, dfix_q, reload_q, ok_en_q, err_en_q;
   logic          addr_valid, rd_issued, stop_pend, irq_q, ack_q;
   logic [DW-1:0] data_q;
   logic          blk_last, job_last;
   logic [AW-1:0] ptr [N_PTR];

   logic start_ok, start_bad, stop_now, rd_go, rd_ack, wr_ack;
   logic bus_err, wr_done, stop_at, fin_ok, finish, hold_after;

   assign start_ok  = (st == ST_IDLE) && ctl_start && mode_ok(cfg_mode);
   assign start_bad = (st == ST_IDLE) && ctl_start && !mode_ok(cfg_mode);
   assign stop_now  = stop_pend || ctl_stop;
   assign rd_go     = rd_issued || (!ctl_pause && !stop_now);
   assign mem_req   = (st == ST_WRITE) || ((st == ST_READ) && rd_go);
   assign rd_ack    = (st == ST_READ) && mem_req && mem_ack;
   assign wr_ack    = (st == ST_WRITE) && mem_ack;
   assign bus_err   = (rd_ack || wr_ack) && mem_err;
   assign wr_done   = wr_ack && !mem_err;
   assign fin_ok    = wr_done && job_last;
   assign stop_at   = stop_now && ((st == ST_WAIT) || (st == ST_GAP) ||
                      ((st == ST_READ) && !rd_issued) || (wr_done && !job_last));
   assign finish    = fin_ok || bus_err || stop_at;
   assign hold_after = (mode_q == MODE_HW_DEMAND) || (blk_last && (mode_q == MODE_HW_BLOCK));

   for (genvar g = 0; g < N_PTR; g++) begin : g_ptr
      dma_chan_addr #(.AW(AW)) u_addr (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (start_ok && !addr_valid),
         .load_val ((g == 0) ? cfg_src_addr : cfg_dst_addr),
         .adv      (wr_done),
         .fixed    ((g == 0) ? sfix_q : dfix_q),
         .width    (width_q),
         .addr     (ptr[g])
      );
   end

   dma_chan_count #(.BLK_W(BLK_W), .XFER_W(XFER_W)) u_count (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (start_ok),
      .blk_init  (cfg_blocks),
      .xfer_init (cfg_xfers),
      .adv       (wr_done),
      .blk_last  (blk_last),
      .job_last  (job_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE;       done_q <= END_NONE;
         mode_q <= '0;        width_q <= '0;
         sfix_q <= 1'b0;      dfix_q <= 1'b0;     reload_q <= 1'b0;
         ok_en_q <= 1'b0;     err_en_q <= 1'b0;   addr_valid <= 1'b0;
         rd_issued <= 1'b0;   stop_pend <= 1'b0;  data_q <= '0;
         irq_q <= 1'b0;       ack_q <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         ack_q <= 1'b0;
         if (st != ST_IDLE && ctl_stop) stop_pend <= 1'b1;
         if (finish) begin
            st        <= ST_IDLE;
            stop_pend <= 1'b0;
            rd_issued <= 1'b0;
            done_q    <= bus_err ? END_ERR : (fin_ok ? END_OK : END_STOP);
            irq_q     <= fin_ok ? ok_en_q : err_en_q;
            ack_q     <= fin_ok && mode_hw(mode_q);
            if (reload_q) addr_valid <= 1'b0;
         end else begin
            case (st)
               ST_IDLE: begin
                  if (start_ok) begin
                     mode_q   <= cfg_mode;       width_q  <= cfg_width;
                     sfix_q   <= cfg_src_fixed;  dfix_q   <= cfg_dst_fixed;
                     reload_q <= cfg_reload;     ok_en_q  <= cfg_ok_irq_en;
                     err_en_q <= cfg_err_irq_en; done_q   <= END_NONE;
                     addr_valid <= 1'b1;
                     st <= mode_hw(cfg_mode) ? ST_WAIT : ST_READ;
                  end else if (start_bad) begin
                     done_q <= END_ERR;
                     irq_q  <= cfg_err_irq_en;
                  end
               end
               ST_WAIT: if (per_req && !ctl_pause) st <= ST_READ;
               ST_GAP:  if (!ctl_pause) st <= ST_READ;
               ST_READ: begin
                  if (rd_ack) begin
                     data_q    <= mem_rdata;
                     rd_issued <= 1'b0;
                     st        <= ST_WRITE;
                  end else if (mem_req) begin
                     rd_issued <= 1'b1;
                  end
               end
               ST_WRITE: begin
                  if (wr_done) begin
                     if (hold_after) begin
                        ack_q <= 1'b1;
                        st    <= ST_WAIT;
                     end else if (blk_last && (mode_q == MODE_SW_BLOCK)) begin
                        st <= ST_GAP;
                     end else begin
                        st <= ST_READ;
                     end
                  end
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

   assign mem_we    = (st == ST_WRITE);
   assign mem_addr  = (st == ST_WRITE) ? ptr[1] : ptr[0];
   assign mem_size  = width_q;
   assign mem_wdata = data_q;
   assign busy      = (st != ST_IDLE);
   assign done_code = done_q;
   assign irq       = irq_q;
   assign per_ack   = ack_q;

   // R13
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
   // R6
   ack_hw_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      per_ack |-> (mode_q >= 3'd2));
   // R8
   pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_pause && !mem_req) |=> (!mem_req || !ctl_pause));
   // R10
   err_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack && mem_err) |=> (!busy && done_code == END_ERR));
   // R11
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (done_code != END_NONE));
   // R4
   hw_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT && !per_req) |=> !mem_req);
endmodule

// File: tb/dma_chan_engine_bench.sv
`timescale 1ns/1ps
module dma_chan_engine_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] cfg_src_addr, cfg_dst_addr;
   logic [1:0]  cfg_width;
   logic        cfg_src_fixed, cfg_dst_fixed;
   logic [3:0]  cfg_blocks;
   logic [15:0] cfg_xfers;
   logic [2:0]  cfg_mode;
   logic        cfg_reload, cfg_ok_irq_en, cfg_err_irq_en;
   logic        ctl_start, ctl_stop, ctl_pause, per_req, per_ack;
   logic        mem_req, mem_we, mem_ack, mem_err, busy, irq;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic [1:0]  mem_size, done_code;

   dma_chan_engine u_dma_chan_engine (.*);

   initial forever #2.5 clk = ~clk;

   int n_checks = 0, n_fail = 0;
   int n_wr, op_idx, err_op, dly, n_irq, n_ack, n_gap, n_prise, n_size_bad, hold;
   bit rand_lat, per_on, pause_prev, req_prev, finished;
   logic [31:0] wr_a [64];
   logic [31:0] wr_d [64];
   bit have = 0;
   logic [31:0] cur_s, cur_d;

   function automatic logic [31:0] pat(input logic [31:0] a);
      return {a[15:0] ^ 16'h5A3C, ~a[15:0]};
   endfunction

   function automatic logic [31:0] stepv(input logic [1:0] w, input bit fx);
      if (fx) return 32'd0;
      return (w == 2'd0) ? 32'd1 : (w == 2'd1) ? 32'd2 : 32'd4;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   // memory responder, peripheral model and monitors
   initial begin
      mem_ack = 0; mem_err = 0; mem_rdata = 0; per_req = 0; hold = 0; dly = 0;
      err_op = -1; op_idx = 0; n_wr = 0; rand_lat = 0; per_on = 0;
      pause_prev = 0; req_prev = 0; n_size_bad = 0;
      forever begin
         @(negedge clk);
         if (mem_ack) begin
            mem_ack = 0; mem_err = 0;
         end else if (mem_req) begin
            if (dly > 0) dly--;
            else begin
               mem_ack = 1;
               mem_err = (op_idx == err_op);
               if (mem_size != cfg_width) n_size_bad++;
               if (!mem_we) mem_rdata = pat(mem_addr);
               else if (!mem_err && n_wr < 64) begin
                  wr_a[n_wr] = mem_addr; wr_d[n_wr] = mem_wdata; n_wr++;
               end
               op_idx++;
               dly = rand_lat ? int'($urandom_range(2, 0)) : 0;
            end
         end
         if (irq) n_irq++;
         if (per_ack) n_ack++;
         if (busy && !mem_req) n_gap++;
         if (ctl_pause && pause_prev && mem_req && !req_prev) n_prise++;
         pause_prev = ctl_pause; req_prev = mem_req;
         if (per_on) begin
            if (per_ack) begin per_req = 0; hold = 2; end
            else if (hold > 0) hold--;
            else per_req = 1;
         end else per_req = 0;
      end
   end

   task automatic run_job(input logic [31:0] src, input logic [31:0] dst, input logic [1:0] w,
                          input bit sfx, input bit dfx, input logic [3:0] blk, input logic [15:0] xf,
                          input logic [2:0] md, input bit rl, input bit oe, input bit ee,
                          input int eop, input int stop_c, input int pause_c, input int hw_hold);
      int beats, cyc, exp_wr, exp_ack, snap, bad;
      logic [31:0] es, ed, ss, ds;
      bit hw, plain;
      hw = (md >= 3'd2);
      es = have ? cur_s : src;
      ed = have ? cur_d : dst;
      ss = stepv(w, sfx);
      ds = stepv(w, dfx);
      beats = (int'(blk) + 1) * (int'(xf) + 1);
      plain = (eop < 0) && (stop_c < 0);
      cfg_src_addr = src; cfg_dst_addr = dst; cfg_width = w;
      cfg_src_fixed = sfx; cfg_dst_fixed = dfx; cfg_blocks = blk; cfg_xfers = xf;
      cfg_mode = md; cfg_reload = rl; cfg_ok_irq_en = oe; cfg_err_irq_en = ee;
      n_wr = 0; op_idx = 0; err_op = eop; n_irq = 0; n_ack = 0; n_gap = 0;
      n_prise = 0; n_size_bad = 0; snap = 0;
      per_on = hw && (hw_hold == 0);
      ctl_start = 1; tick(); ctl_start = 0;
      cyc = 0;
      while (busy && cyc < 20000) begin
         if (hw && hw_hold > 0 && cyc == hw_hold) begin
            check(op_idx == 0, "R4", "requests before per_req", op_idx, 0);
            check(busy, "R4", "armed busy", busy, 1);
            per_on = 1;
         end
         ctl_stop = (cyc == stop_c);
         if (cyc == pause_c) ctl_pause = 1;
         if (pause_c >= 0 && cyc == pause_c + 4) snap = n_wr;
         if (pause_c >= 0 && cyc == pause_c + 20) begin
            check(n_wr == snap, "R8", "writes during pause", n_wr, snap);
            ctl_pause = 0;
         end
         tick(); cyc++;
      end
      ctl_stop = 0; ctl_pause = 0; per_on = 0;
      check(!busy, "R2", "job ended", busy, 0);
      tick(); tick();
      if (eop >= 0) begin
         check(done_code == 2'd2, "R10", "done code after bus error", done_code, 2);
         check(n_wr == eop / 2, "R10", "writes before error", n_wr, eop / 2);
      end else if (stop_c >= 0) begin
         check(done_code == 2'd3, "R9", "done code after stop", done_code, 3);
         check(n_wr < beats, "R9", "writes after stop", n_wr, beats);
      end else begin
         check(done_code == 2'd1, "R2", "done code", done_code, 1);
         check(n_wr == beats, "R2", "beat count", n_wr, beats);
      end
      bad = -1;
      for (int i = 0; i < n_wr; i++)
         if (bad < 0 && (wr_a[i] != ed + 32'(i) * ds || wr_d[i] != pat(es + 32'(i) * ss))) bad = i;
      check(bad < 0, "R1/R3/R7", "first wrong beat", bad, -1);
      check(n_size_bad == 0, "R3", "mem_size mismatches", n_size_bad, 0);
      check(n_irq == ((plain ? oe : ee) ? 1 : 0), "R11", "irq pulses", n_irq, (plain ? oe : ee) ? 1 : 0);
      if (pause_c >= 0) check(n_prise == 0, "R8", "requests started in pause", n_prise, 0);
      if (plain) begin
         exp_ack = (md == 3'd2) ? beats : (md == 3'd3) ? int'(xf) + 1 : (md == 3'd4) ? 1 : 0;
         check(n_ack == exp_ack, "R6", "per_ack pulses", n_ack, exp_ack);
         if (!hw && pause_c < 0) begin
            exp_wr = (md == 3'd0) ? int'(xf) : 0;
            check(n_gap == exp_wr, "R5", "idle port cycles", n_gap, exp_wr);
         end
      end
      if (rl) have = 0;
      else begin
         have = 1;
         cur_s = es + 32'(n_wr) * ss;
         cur_d = ed + 32'(n_wr) * ds;
      end
   endtask

   initial begin
      int unsigned seed;
      seed = $urandom(7919);
      rst_n = 0; ctl_start = 0; ctl_stop = 0; ctl_pause = 0; finished = 0;
      cfg_src_addr = 0; cfg_dst_addr = 0; cfg_width = 0; cfg_src_fixed = 0;
      cfg_dst_fixed = 0; cfg_blocks = 0; cfg_xfers = 0; cfg_mode = 0;
      cfg_reload = 0; cfg_ok_irq_en = 0; cfg_err_irq_en = 0;
      tick(); tick(); tick();
      // R14
      check(!busy && !mem_req && !irq && !per_ack && done_code == 0, "R14", "reset outputs",
            {busy, mem_req, irq, per_ack, done_code}, 0);
      rst_n = 1; tick();
      check(!busy && done_code == 0, "R14", "after release", busy, 0);

      // word burst and byte block with fixed source (R1, R2, R3, R5)
      run_job(32'h100, 32'h800, 2'd2, 0, 0, 4'd3, 16'd2, 3'd1, 1, 1, 0, -1, -1, -1, 0);
      run_job(32'h123, 32'h901, 2'd0, 1, 0, 4'd1, 16'd3, 3'd0, 1, 1, 1, -1, -1, -1, 0);
      // hardware modes (R4, R6)
      run_job(32'h200, 32'hA00, 2'd1, 0, 0, 4'd1, 16'd1, 3'd2, 1, 0, 1, -1, -1, -1, 8);
      run_job(32'h240, 32'hA40, 2'd2, 0, 1, 4'd2, 16'd2, 3'd3, 1, 1, 0, -1, -1, -1, 0);
      run_job(32'h280, 32'hA80, 2'd2, 0, 0, 4'd3, 16'd1, 3'd4, 1, 1, 0, -1, -1, -1, 6);
      // R7: continuation without reload, then restart at programmed addresses
      run_job(32'h040, 32'h900, 2'd2, 0, 0, 4'd1, 16'd1, 3'd1, 0, 0, 0, -1, -1, -1, 0);
      run_job(32'h300, 32'hB00, 2'd2, 0, 0, 4'd1, 16'd0, 3'd1, 1, 0, 0, -1, -1, -1, 0);
      run_job(32'h300, 32'hB00, 2'd1, 0, 0, 4'd0, 16'd1, 3'd0, 1, 0, 0, -1, -1, -1, 0);
      // largest block count (R2)
      run_job(32'h400, 32'hC00, 2'd2, 0, 0, 4'd15, 16'd2, 3'd1, 1, 1, 0, -1, -1, -1, 0);
      // pause with wait states (R8)
      rand_lat = 1;
      run_job(32'h500, 32'hD00, 2'd2, 0, 0, 4'd3, 16'd3, 3'd1, 1, 1, 0, -1, -1, 6, 0);
      // forced stop (R9) and bus errors (R10)
      run_job(32'h600, 32'hE00, 2'd1, 0, 0, 4'd3, 16'd7, 3'd1, 1, 1, 1, -1, 10, -1, 0);
      run_job(32'h700, 32'hE80, 2'd2, 0, 0, 4'd1, 16'd3, 3'd0, 1, 1, 1, 5, -1, -1, 0);
      run_job(32'h780, 32'hF00, 2'd0, 0, 0, 4'd1, 16'd1, 3'd2, 1, 0, 1, 0, -1, -1, 0);

      // R12: undefined mode code
      cfg_mode = 3'd6; cfg_err_irq_en = 1; n_irq = 0; op_idx = 0;
      ctl_start = 1; tick(); ctl_start = 0;
      check(!busy && done_code == 2'd2, "R12", "bad mode outcome", done_code, 2);
      tick(); tick();
      check(op_idx == 0 && n_irq == 1, "R12", "bad mode requests/irq", op_idx, 0);

      // constrained random jobs
      for (int j = 0; j < 30; j++) begin
         run_job(32'($urandom_range(255, 0)) * 4, 32'h1000 + 32'($urandom_range(255, 0)) * 4,
                 2'($urandom_range(2, 0)), 1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)),
                 4'($urandom_range(3, 0)), 16'($urandom_range(3, 0)), 3'($urandom_range(4, 0)),
                 1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)),
                 -1, -1, -1, 0);
      end

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      #900000;
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog run did not end actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end
endmodule